// File: doc/BRIEF.md
# Odd-Element Saturating Doubling Multiply-Accumulate Unit

This block is a 128-bit SIMD datapath that folds a widening, doubled, signed product into an accumulator vector. It has two source vectors made of narrow signed elements and one accumulator vector made of wide signed lanes, where each wide lane is twice the width of a narrow element. Each wide lane takes its operands from the upper (odd-indexed) narrow element of the matching pair in each source.

For each lane, the block multiplies the two narrow elements and doubles the product. It clamps that doubled product to the signed range of the lane. It then adds the clamped value to the accumulator lane and clamps the sum to the same range. Every lane is written on every operation, because there is no per-lane enable.

A 2-bit size code selects the lane width. The reserved code passes the accumulator through unchanged and marks the operation as illegal. A sticky flag collects every clamp event until it is cleared. Results are registered and appear one cycle after the input strobe.

Top module: `dmac_top`

## Requirements
- R1: The size code selects the lane width as 8 shifted left by the code. Code 01 gives eight 16-bit lanes with 8-bit source elements. Code 10 gives four 32-bit lanes with 16-bit source elements. Code 11 gives two 64-bit lanes with 32-bit source elements. Lane e occupies bits [e*LW +: LW] of the accumulator vectors.
- R2: Lane e reads source element 2*e+1 of each source vector, at bits [(2e+1)*HW +: HW], where HW = LW/2. The even-indexed elements have no effect on the result.
- R3: Both source elements are signed. The value 2*a*b is clamped to the range [-2^(LW-1), 2^(LW-1)-1]. When both elements equal -2^(HW-1), the clamped value is 2^(LW-1)-1. In every other case the value is exact.
- R4: The clamped product is added to the signed accumulator lane, and the sum is clamped to the same range. A positive overflow gives 2^(LW-1)-1 and a negative overflow gives -2^(LW-1).
- R5: Every lane of the accumulator output is recomputed on every operation with a legal size code.
- R6: Size code 00 is illegal. The accumulator output equals the accumulator input, illegal_op is 1 for that result, and the sticky flag is not set by that operation. A legal operation returns illegal_op to 0.
- R7: When in_valid is 1 at a clock edge, acc_out and illegal_op show that operation after the edge, and out_valid is 1 for exactly that cycle. When in_valid is 0, acc_out and illegal_op hold their values.
- R8: sat_sticky becomes 1 after any legal operation in which either clamp step changed a value in any lane. It stays 1 until sat_clr is seen at a clock edge. If a clear and a clamping operation arrive at the same edge, the flag is 1.
- R9: After reset, out_valid, illegal_op and sat_sticky are 0 and acc_out is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Strobe that accepts an operation |
| size_code | input | 2 | Lane width select (00 is illegal) |
| src_a | input | 128 | First narrow-element source vector |
| src_b | input | 128 | Second narrow-element source vector |
| acc_in | input | 128 | Wide-lane accumulator input |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| acc_out | output | 128 | Updated accumulator vector |
| illegal_op | output | 1 | Last accepted operation used size code 00 |
| sat_sticky | output | 1 | Sticky saturation indication |

## Verification
The lane arithmetic is combinational and feeds a single register stage. acc_out, illegal_op and the sticky flag for an operation are therefore due at the first rising edge after the edge that sampled in_valid, and out_valid rises at that same edge. The bench drives each operation on a falling edge and drops the strobe on the next falling edge, which comes after the capturing rising edge. It compares all outputs at that point against a model that extracts the lanes arithmetically. Hold and clear behaviour is checked one or more full cycles later with no strobe applied, so each comparison sees a settled register value.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int VEC_W      = 128;
  localparam int MIN_LANE_W = 16;
  localparam int NUM_SIZES  = 3;

  typedef enum logic [1:0] {
    SZ_RSVD = 2'b00,
    SZ_L16  = 2'b01,
    SZ_L32  = 2'b10,
    SZ_L64  = 2'b11
  } size_e;
endpackage

// File: rtl/dmac_lane.sv
module dmac_lane #(
  parameter int LW = 16
) (
  input  logic [LW/2-1:0] a_i,
  input  logic [LW/2-1:0] b_i,
  input  logic [LW-1:0]   acc_i,
  output logic [LW-1:0]   res_o,
  output logic            sat_o
);
  localparam int HW = LW / 2;
  localparam logic [LW-1:0] MAXV = {1'b0, {(LW-1){1'b1}}};
  localparam logic [LW-1:0] MINV = {1'b1, {(LW-1){1'b0}}};
  localparam logic [HW-1:0] HMIN = {1'b1, {(HW-1){1'b0}}};

  logic signed [LW-1:0] a_ext, b_ext, prod;
  logic [LW-1:0]        dbl_sat;
  logic                 prod_clamp;
  logic [LW:0]          sum;
  logic                 sum_ovf;

  assign a_ext = {{HW{a_i[HW-1]}}, a_i};
  assign b_ext = {{HW{b_i[HW-1]}}, b_i};
  assign prod  = a_ext * b_ext;

  // Only min*min doubles past the positive limit
  assign prod_clamp = (a_i == HMIN) && (b_i == HMIN);
  assign dbl_sat    = prod_clamp ? MAXV : {prod[LW-2:0], 1'b0};

  assign sum     = {acc_i[LW-1], acc_i} + {dbl_sat[LW-1], dbl_sat};
  assign sum_ovf = sum[LW] ^ sum[LW-1];

  always_comb begin
    if (sum_ovf) res_o = sum[LW] ? MINV : MAXV;
    else         res_o = sum[LW-1:0];
  end

  assign sat_o = prod_clamp | sum_ovf;
endmodule

// File: rtl/dmac_core.sv
module dmac_core
  import dmac_pkg::*;
#(
  parameter int VW   = VEC_W,
  parameter int MINW = MIN_LANE_W,
  parameter int NSZ  = NUM_SIZES
) (
  input  logic [1:0]    size_code,
  input  logic [VW-1:0] src_a,
  input  logic [VW-1:0] src_b,
  input  logic [VW-1:0] acc_in,
  output logic [VW-1:0] acc_res,
  output logic          any_sat,
  output logic          illegal
);
  logic [NSZ-1:0][VW-1:0] res_by_sz;
  logic [NSZ-1:0]         sat_by_sz;

  for (genvar k = 0; k < NSZ; k++) begin : g_size
    localparam int LW = MINW << k;
    localparam int HW = LW / 2;
    localparam int NL = VW / LW;
    logic [VW-1:0] r;
    logic [NL-1:0] lsat;
    for (genvar e = 0; e < NL; e++) begin : g_lane
      dmac_lane #(.LW(LW)) u_lane (
        .a_i   (src_a[(2*e+1)*HW +: HW]),
        .b_i   (src_b[(2*e+1)*HW +: HW]),
        .acc_i (acc_in[e*LW +: LW]),
        .res_o (r[e*LW +: LW]),
        .sat_o (lsat[e])
      );
    end
    assign res_by_sz[k] = r;
    assign sat_by_sz[k] = |lsat;
  end

  always_comb begin
    illegal = 1'b0;
    acc_res = acc_in;
    any_sat = 1'b0;
    unique case (size_e'(size_code))
      SZ_L16: begin acc_res = res_by_sz[0]; any_sat = sat_by_sz[0]; end
      SZ_L32: begin acc_res = res_by_sz[1]; any_sat = sat_by_sz[1]; end
      SZ_L64: begin acc_res = res_by_sz[2]; any_sat = sat_by_sz[2]; end
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/dmac_top.sv
module dmac_top
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        size_code,
  input  logic [VEC_W-1:0]  src_a,
  input  logic [VEC_W-1:0]  src_b,
  input  logic [VEC_W-1:0]  acc_in,
  input  logic              sat_clr,
  output logic              out_valid,
  output logic [VEC_W-1:0]  acc_out,
  output logic              illegal_op,
  output logic              sat_sticky
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [VEC_W-1:0] core_res;
  logic             core_sat, core_ill;
  logic [VEC_W-1:0] acc_d;
  logic             ill_d, sticky_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  dmac_core u_core (
    .size_code (size_code),
    .src_a     (src_a),
    .src_b     (src_b),
    .acc_in    (acc_in),
    .acc_res   (core_res),
    .any_sat   (core_sat),
    .illegal   (core_ill)
  );

  always_comb begin
    acc_d    = acc_out;
    ill_d    = illegal_op;
    sticky_d = sat_clr ? 1'b0 : sat_sticky;
    if (in_valid) begin
      acc_d    = core_res;
      ill_d    = core_ill;
      sticky_d = sticky_d | (core_sat & ~core_ill);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid  <= 1'b0;
      acc_out    <= '0;
      illegal_op <= 1'b0;
      sat_sticky <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      sat_sticky <= sticky_d;
      if (in_valid) begin
        acc_out    <= acc_d;
        illegal_op <= ill_d;
      end
    end
  end
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk (
  input logic         clk,
  input logic         rst_ok,
  input logic         in_valid,
  input logic [1:0]   size_code,
  input logic [127:0] acc_in,
  input logic         sat_clr,
  input logic         out_valid,
  input logic [127:0] acc_out,
  input logic         illegal_op,
  input logic         sat_sticky
);
  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> out_valid);
  assert_valid_drops_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> !out_valid);
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> ($stable(acc_out) && $stable(illegal_op)));
  assert_illegal_pass_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && size_code == 2'b00) |=> (illegal_op && acc_out == $past(acc_in)));
  assert_illegal_no_sat_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && size_code == 2'b00 && !sat_sticky && !sat_clr) |=> !sat_sticky);
  assert_legal_clears_flag_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && size_code != 2'b00) |=> !illegal_op);
  assert_sticky_holds_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (sat_sticky && !sat_clr) |=> sat_sticky);
  assert_sticky_clear_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (sat_clr && !in_valid) |=> !sat_sticky);
endmodule

bind dmac_top dmac_chk u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .in_valid   (in_valid),
  .size_code  (size_code),
  .acc_in     (acc_in),
  .sat_clr    (sat_clr),
  .out_valid  (out_valid),
  .acc_out    (acc_out),
  .illegal_op (illegal_op),
  .sat_sticky (sat_sticky)
);

// File: tb/tb_dmac_top.sv
module tb_dmac_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   size_code;
  logic [127:0] src_a, src_b, acc_in;
  logic         sat_clr;
  logic         out_valid;
  logic [127:0] acc_out;
  logic         illegal_op, sat_sticky;

  int n_chk = 0;
  int n_bad = 0;
  logic [127:0] lfsr = 128'h1234_5678_9abc_def0_0fed_cba9_8765_4321;

  always #4 clk = ~clk;

  dmac_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_code(size_code),
    .src_a(src_a), .src_b(src_b), .acc_in(acc_in), .sat_clr(sat_clr),
    .out_valid(out_valid), .acc_out(acc_out), .illegal_op(illegal_op),
    .sat_sticky(sat_sticky)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] sx(input logic [127:0] v, input int w);
    logic [127:0] m;
    m = (w == 128) ? '1 : ((128'd1 << w) - 1);
    v = v & m;
    if (v[w-1]) v = v | ~m;
    return v;
  endfunction

  // Reference: per-lane arithmetic from the requirement text
  task automatic model(input logic [1:0] sz, input logic [127:0] a, input logic [127:0] b,
                       input logic [127:0] c, output logic [127:0] res, output logic sat);
    int lw, hw;
    logic signed [127:0] ea, eb, ec, p, s, mx, mn;
    logic [127:0] lm;
    res = '0; sat = 1'b0;
    if (sz == 2'b00) begin res = c; return; end
    lw = 8 << sz; hw = lw / 2;
    mx = (128'sd1 <<< (lw - 1)) - 1;
    mn = -mx - 1;
    lm = (128'd1 << lw) - 1;
    for (int e = 0; e < 128 / lw; e++) begin
      ea = sx(a >> ((2*e+1)*hw), hw);
      eb = sx(b >> ((2*e+1)*hw), hw);
      ec = sx(c >> (e*lw), lw);
      p = 2 * ea * eb;
      if (p > mx) begin p = mx; sat = 1'b1; end
      if (p < mn) begin p = mn; sat = 1'b1; end
      s = ec + p;
      if (s > mx) begin s = mx; sat = 1'b1; end
      if (s < mn) begin s = mn; sat = 1'b1; end
      res = res | ((s & lm) << (e*lw));
    end
  endtask

  task automatic op(input logic [1:0] sz, input logic [127:0] a, input logic [127:0] b,
                    input logic [127:0] c, input logic clr);
    @(negedge clk);
    size_code = sz; src_a = a; src_b = b; acc_in = c; sat_clr = clr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; sat_clr = 1'b0;
  endtask

  task automatic run_cmp(input string req, input logic [1:0] sz, input logic [127:0] a,
                         input logic [127:0] b, input logic [127:0] c);
    logic [127:0] er; logic es;
    model(sz, a, b, c, er, es);
    op(sz, a, b, c, 1'b0);
    chk(req, acc_out, er);
    chk(req, {127'd0, out_valid}, 128'd1);
  endtask

  function automatic logic [127:0] nxt();
    lfsr = {lfsr[126:0], lfsr[127] ^ lfsr[125] ^ lfsr[100] ^ lfsr[98]};
    lfsr = {lfsr[63:0] ^ lfsr[127:64], lfsr[127:64]} ^ 128'h5a5a;
    return lfsr;
  endfunction

  task automatic t_reset();
    chk("R9 acc", acc_out, '0);
    chk("R9 valid", {127'd0, out_valid}, '0);
    chk("R9 illegal", {127'd0, illegal_op}, '0);
    chk("R9 sticky", {127'd0, sat_sticky}, '0);
  endtask

  task automatic t_sizes();
    // R1: same operands, three lane widths
    logic [127:0] a, b, c;
    a = 128'h0102_0304_0506_0708_090a_0b0c_0d0e_0f10;
    b = 128'h0203_0405_0607_0809_0a0b_0c0d_0e0f_1011;
    c = 128'h0000_1111_2222_3333_4444_5555_6666_7777;
    run_cmp("R1 size16", 2'b01, a, b, c);
    run_cmp("R1 size32", 2'b10, a, b, c);
    run_cmp("R1 size64", 2'b11, a, b, c);
  endtask

  task automatic t_odd_only();
    // R2: change only even elements; result must not move
    logic [127:0] a, b, c, e16, e32;
    logic s;
    a = 128'h0300_0500_0700_0900_0b00_0d00_0f00_1100;
    b = 128'h0200_0200_0200_0200_0200_0200_0200_0200;
    c = '0;
    model(2'b01, a, b, c, e16, s);
    op(2'b01, a | 128'h00ff_00ff_00ff_00ff_00ff_00ff_00ff_00ff,
              b | 128'h007f_007f_007f_007f_007f_007f_007f_007f, c, 1'b0);
    chk("R2 even ignored 16", acc_out, e16);
    model(2'b10, a, b, c, e32, s);
    op(2'b10, a ^ 128'h0000_ffff_0000_ffff_0000_ffff_0000_ffff,
              b ^ 128'h0000_1234_0000_1234_0000_1234_0000_1234, c, 1'b0);
    chk("R2 even ignored 32", acc_out, e32);
  endtask

  task automatic t_prod_sat();
    // R3: min*min clamps to max, min*max stays exact
    op(2'b01, {8{16'h8000}}, {8{16'h8000}}, '0, 1'b0);
    chk("R3 min*min 16", acc_out, {8{16'h7fff}});
    op(2'b11, {2{64'h8000_0000_0000_0000}}, {2{64'h8000_0000_0000_0000}}, '0, 1'b0);
    chk("R3 min*min 64", acc_out, {2{64'h7fff_ffff_ffff_ffff}});
    op(2'b10, {4{32'h8000_0000}}, {4{32'h7fff_0000}}, '0, 1'b0);
    chk("R3 min*max exact 32", acc_out, {4{32'h8001_0000}});
  endtask

  task automatic t_acc_sat();
    // R4: positive and negative accumulate clamp
    op(2'b01, {8{16'h4000}}, {8{16'h4000}}, {8{16'h7000}}, 1'b0);
    chk("R4 pos clamp", acc_out, {8{16'h7fff}});
    op(2'b10, {4{32'h8000_0000}}, {4{32'h7fff_0000}}, {4{32'h9000_0000}}, 1'b0);
    chk("R4 neg clamp", acc_out, {4{32'h8000_0000}});
    run_cmp("R4 mixed", 2'b11, 128'h7fff_ffff_0000_0000_8000_0000_0000_0000,
            128'h7fff_ffff_0000_0000_7fff_ffff_0000_0000,
            128'h4000_0000_0000_0000_c000_0000_0000_0000);
  endtask

  task automatic t_all_lanes();
    // R5: pseudo-random operands at every size
    for (int i = 0; i < 30; i++) begin
      logic [127:0] a, b, c;
      a = nxt(); b = nxt(); c = nxt();
      run_cmp("R5 random", 2'(1 + (i % 3)), a, b, c);
    end
  endtask

  task automatic t_illegal();
    logic [127:0] c;
    op(2'b00, 128'd0, 128'd0, '0, 1'b1);
    c = 128'hdead_beef_0123_4567_89ab_cdef_1111_2222;
    op(2'b00, {8{16'h8000}}, {8{16'h8000}}, c, 1'b0);
    chk("R6 passthrough", acc_out, c);
    chk("R6 flag", {127'd0, illegal_op}, 128'd1);
    chk("R6 no sticky", {127'd0, sat_sticky}, 128'd0);
    op(2'b01, '0, '0, '0, 1'b0);
    chk("R6 flag drops", {127'd0, illegal_op}, 128'd0);
  endtask

  task automatic t_latency_hold();
    logic [127:0] held;
    op(2'b10, 128'h0001_0000_0001_0000_0001_0000_0001_0000, {4{32'h0003_0000}}, '0, 1'b0);
    held = acc_out;
    chk("R7 first result", held, {4{32'h0000_0006}});
    @(negedge clk);
    chk("R7 valid pulse", {127'd0, out_valid}, 128'd0);
    src_a = '1; acc_in = 128'h55; size_code = 2'b00;
    @(negedge clk); @(negedge clk);
    chk("R7 hold acc", acc_out, held);
    chk("R7 hold illegal", {127'd0, illegal_op}, 128'd0);
  endtask

  task automatic t_sticky();
    op(2'b01, '0, '0, '0, 1'b1);
    chk("R8 cleared", {127'd0, sat_sticky}, 128'd0);
    op(2'b01, {8{16'h8000}}, {8{16'h8000}}, '0, 1'b0);
    chk("R8 set", {127'd0, sat_sticky}, 128'd1);
    op(2'b10, '0, '0, '0, 1'b0);
    chk("R8 held", {127'd0, sat_sticky}, 128'd1);
    @(negedge clk); sat_clr = 1'b1;
    @(negedge clk); sat_clr = 1'b0;
    chk("R8 clear input", {127'd0, sat_sticky}, 128'd0);
    op(2'b11, '0, '0, {2{64'h7fff_ffff_ffff_ffff}}, 1'b0);
    chk("R8 no clamp no set", {127'd0, sat_sticky}, 128'd0);
    op(2'b01, {8{16'h4000}}, {8{16'h4000}}, {8{16'h7000}}, 1'b1);
    chk("R8 set beats clear", {127'd0, sat_sticky}, 128'd1);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    join_none
    rst_n = 1'b0; in_valid = 1'b0; size_code = 2'b01; sat_clr = 1'b0;
    src_a = '0; src_b = '0; acc_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sizes();
    t_odd_only();
    t_prod_sat();
    t_acc_sat();
    t_all_lanes();
    t_illegal();
    t_latency_hold();
    t_sticky();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule